// File: doc/BRIEF.md
# Posted Write Buffer with Read Merge

This block sits between the bus masters and a memory controller. When it is enabled, a master write is taken into a small store of posted entries and acknowledged at once, so the master never waits for memory write latency. The entries are written out to memory later, in the order they were allocated. A later write to a word that is already posted is folded into the same entry.

A read is sent to memory ahead of any pending posted write. The data it returns is the memory word with the posted bytes laid over it, so the memory array and the buffer together look like one coherent store. No drain is forced first.

Clearing the enable, or pulsing the software flush control, starts a blocking drain. The memory port then carries only posted writes until the buffer is empty. No master access is acknowledged during that time. After reset the block is disabled, and master writes go straight through to memory. Memory is modelled as a request/grant port: a request is held until a grant, a write completes in the granted cycle, and read data is valid in the granted cycle.

Top module: `pwb_top`

## Requirements
- R1: After reset `flush_bit` and `flush_busy` are 0, the buffer is empty and the enable input governs. While `wb_en` is 0 and the buffer is empty, a master write is placed on the memory port with its own address, data and byte enables, and `m_ack` equals `mem_gnt`.
- R2: While `wb_en` is 1 and no flush is busy, a master write to a word not held in the buffer is acknowledged in the same cycle without using the memory port, and a new entry is allocated. Byte lane k is `data[8k+7:8k]`, qualified by byte-enable bit k.
- R3: A write to a word already held in an entry that is not at the drain head replaces only the bytes whose enable bit is set. It ORs the byte enables into that entry and allocates no new entry.
- R4: The buffer holds at most DEPTH (default 4) entries. A write that misses while the buffer is full gets no acknowledge until an entry drains. A write that hits the entry at the drain head also waits until that entry has drained.
- R5: Whenever the buffer is non-empty and the memory port is not carrying a master read, the oldest entry is presented as a memory write with its stored address, data and byte enables. It is removed on grant, so entries reach memory in allocation order.
- R6: A read returns, on grant, the memory word with each byte whose enable is set in a matching buffered entry replaced by the buffered byte. The result equals the data most recently written to that word by acknowledged master writes.
- R7: When a flush is not busy, a pending master read takes the memory port ahead of any buffered write.
- R8: When `wb_en` is 0 and the buffer is non-empty, `flush_busy` is 1. No master access is acknowledged, and the memory port carries only the head entry until the buffer is empty.
- R9: A one-cycle pulse on `flush_set` sets `flush_bit`. While `flush_bit` is 1 and the buffer is non-empty, the drain blocks masters as in R8. `flush_bit` clears in the cycle after the buffer is seen empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_en | input | 1 | Buffer enable; clearing it drains the buffer |
| flush_set | input | 1 | One-cycle pulse that requests a software flush |
| flush_bit | output | 1 | Software flush request, self-clearing |
| flush_busy | output | 1 | Blocking drain in progress |
| m_req | input | 1 | Master request, held until acknowledge |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | AW | Master word address |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_ack | output | 1 | Master access complete |
| m_rdata | output | 32 | Merged read data, valid with m_ack on a read |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_gnt | input | 1 | Memory grant for the current request |
| mem_rdata | input | 32 | Memory read data, valid in the grant cycle |

## Verification
The assertions assume that a master holds `m_req` and its address, data and byte enables steady until `m_ack`. They also assume that `mem_rdata` is only consumed in a granted read cycle and that `flush_set` is a single-cycle pulse. The bench drives inputs only on falling edges. It starts a new master operation only after the previous one has been acknowledged, and it raises `flush_set` for exactly one cycle. Grant patterns alternate between random, always-on and withheld windows. The withheld windows fill the buffer and provoke stalls, flushes and disables with entries still posted.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  typedef struct packed {
    logic [LANES-1:0] be;
    logic [DW-1:0]    data;
  } wb_word_t;

  // Replace the lanes of base selected by sel with the lanes of top.
  function automatic logic [DW-1:0] lane_overlay(logic [DW-1:0] base,
                                                 logic [DW-1:0] top,
                                                 logic [LANES-1:0] sel);
    logic [DW-1:0] r;
    r = base;
    for (int k = 0; k < LANES; k++)
      if (sel[k]) r[8*k +: 8] = top[8*k +: 8];
    return r;
  endfunction

  // Fold a newer partial write into an older posted word.
  function automatic wb_word_t word_fold(wb_word_t old_w, wb_word_t new_w);
    wb_word_t r;
    r.data = lane_overlay(old_w.data, new_w.data, new_w.be);
    r.be   = old_w.be | new_w.be;
    return r;
  endfunction
endpackage

// File: rtl/pwb_store.sv
module pwb_store
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] look_addr,
  input  logic          do_push,
  input  logic          do_fold,
  input  logic          do_pop,
  input  wb_word_t      in_word,
  output logic          hit,
  output logic          hit_head,
  output wb_word_t      hit_word,
  output logic [AW-1:0] head_addr,
  output wb_word_t      head_word,
  output logic [CW-1:0] count
);
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0]    addr_q [DEPTH];
  wb_word_t         word_q [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [DEPTH-1:0] match;

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = vld_q[i] && (addr_q[i] == look_addr);
  end

  always_comb begin
    hit_word = '0;
    for (int i = 0; i < DEPTH; i++)
      if (match[i]) hit_word = word_q[i];
  end

  assign hit       = |match;
  assign hit_head  = match[head_q];
  assign head_addr = addr_q[head_q];
  assign head_word = word_q[head_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      count  <= '0;
    end else begin
      if (do_pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= ptr_next(head_q);
      end
      if (do_push) begin
        vld_q[tail_q] <= 1'b1;
        tail_q        <= ptr_next(tail_q);
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      addr_q[tail_q] <= look_addr;
      word_q[tail_q] <= in_word;
    end
    for (int i = 0; i < DEPTH; i++)
      if (do_fold && match[i]) word_q[i] <= word_fold(word_q[i], in_word);
  end
endmodule

// File: rtl/pwb_flush_ctl.sv
module pwb_flush_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wb_en,
  input  logic flush_set,
  input  logic buf_empty,
  output logic flush_bit,
  output logic flush_busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flush_bit <= 1'b0;
    else if (flush_set)  flush_bit <= 1'b1;
    else if (buf_empty)  flush_bit <= 1'b0;
  end

  assign flush_busy = (flush_bit || !wb_en) && !buf_empty;
endmodule

// File: rtl/pwb_route.sv
module pwb_route
  import pwb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             wb_en,
  input  logic             busy,
  input  logic             empty,
  input  logic             full,
  input  logic             m_req,
  input  logic             m_we,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  input  logic [LANES-1:0] m_be,
  input  logic             hit,
  input  logic             hit_head,
  input  wb_word_t         hit_word,
  input  logic [AW-1:0]    head_addr,
  input  wb_word_t         head_word,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic             m_ack,
  output logic [DW-1:0]    m_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [LANES-1:0] mem_be,
  output logic             ev_rd_go,
  output logic             ev_pass,
  output logic             ev_push,
  output logic             ev_fold,
  output logic             ev_drain,
  output logic             ev_pop
);
  logic wr_buf, buf_ok;

  assign ev_rd_go = m_req && !m_we && !busy;
  assign ev_pass  = m_req && m_we && !wb_en && empty;
  assign wr_buf   = m_req && m_we && wb_en && !busy;
  assign buf_ok   = wr_buf && (hit ? !hit_head : !full);
  assign ev_push  = buf_ok && !hit;
  assign ev_fold  = buf_ok && hit;
  assign ev_drain = !empty && !ev_rd_go;
  assign ev_pop   = ev_drain && mem_gnt;

  assign mem_req   = ev_rd_go || ev_pass || ev_drain;
  assign mem_we    = !ev_rd_go;
  assign mem_addr  = (ev_rd_go || ev_pass) ? m_addr : head_addr;
  assign mem_wdata = ev_pass ? m_wdata : head_word.data;
  assign mem_be    = ev_pass ? m_be : head_word.be;

  assign m_ack   = ((ev_rd_go || ev_pass) && mem_gnt) || buf_ok;
  assign m_rdata = lane_overlay(mem_rdata, hit_word.data, hit_word.be);
endmodule

// File: rtl/pwb_top.sv
module pwb_top
  import pwb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_en,
  input  logic             flush_set,
  output logic             flush_bit,
  output logic             flush_busy,
  input  logic             m_req,
  input  logic             m_we,
  input  logic [AW-1:0]    m_addr,
  input  logic [DW-1:0]    m_wdata,
  input  logic [LANES-1:0] m_be,
  output logic             m_ack,
  output logic [DW-1:0]    m_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [LANES-1:0] mem_be,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata
);
  logic          hit, hit_head, empty, full;
  wb_word_t      hit_word, head_word, in_word;
  logic [AW-1:0] head_addr;
  logic [CW-1:0] count;
  logic          ev_rd_go, ev_pass, ev_push, ev_fold, ev_drain, ev_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign in_word = '{be: m_be, data: m_wdata};

  pwb_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .look_addr(m_addr),
    .do_push(ev_push), .do_fold(ev_fold), .do_pop(ev_pop), .in_word(in_word),
    .hit(hit), .hit_head(hit_head), .hit_word(hit_word),
    .head_addr(head_addr), .head_word(head_word), .count(count)
  );

  pwb_flush_ctl flush_i (
    .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .flush_set(flush_set),
    .buf_empty(empty), .flush_bit(flush_bit), .flush_busy(flush_busy)
  );

  pwb_route #(.AW(AW)) route_i (
    .wb_en(wb_en), .busy(flush_busy), .empty(empty), .full(full),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
    .hit(hit), .hit_head(hit_head), .hit_word(hit_word),
    .head_addr(head_addr), .head_word(head_word),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .m_ack(m_ack), .m_rdata(m_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .ev_rd_go(ev_rd_go), .ev_pass(ev_pass), .ev_push(ev_push),
    .ev_fold(ev_fold), .ev_drain(ev_drain), .ev_pop(ev_pop)
  );
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wb_en,
  input logic          flush_set,
  input logic          flush_bit,
  input logic          flush_busy,
  input logic          m_req,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata,
  input logic          m_ack,
  input logic [31:0]   m_rdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [31:0]   mem_rdata,
  input logic [CW-1:0] count,
  input logic          hit,
  input logic [AW-1:0] head_addr,
  input logic          ev_push,
  input logic          ev_fold,
  input logic          ev_pop
);
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_en && count == '0 && m_req && m_we) |->
      (mem_req && mem_we && mem_addr == m_addr && mem_wdata == m_wdata));

  p_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && !ev_pop) |=> (count == $past(count) + 1'b1));

  p_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fold && !ev_pop) |=> $stable(count));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && m_req && m_we && !hit) |-> !m_ack);

  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && !ev_push) |=> (count == $past(count) - 1'b1));

  p_merge_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ack && !m_we && !hit) |-> (m_rdata == mem_rdata));

  p_read_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we && !flush_busy) |-> (mem_req && !mem_we && mem_addr == m_addr));

  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> (!m_ack && mem_req && mem_we && mem_addr == head_addr));

  p_flush_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_bit && count != '0) |=> flush_bit);

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_bit && count == '0 && !flush_set) |=> !flush_bit);
endmodule

bind pwb_top pwb_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .flush_set(flush_set),
  .flush_bit(flush_bit), .flush_busy(flush_busy),
  .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
  .m_ack(m_ack), .m_rdata(m_rdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .count(count), .hit(hit), .head_addr(head_addr),
  .ev_push(ev_push), .ev_fold(ev_fold), .ev_pop(ev_pop)
);

// File: tb/pwb_top_tb_top.sv
module pwb_top_tb_top;
  localparam int AW    = 16;
  localparam int NCYC  = 1300;
  localparam int CAP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          wb_en, flush_set, flush_bit, flush_busy;
  logic          m_req, m_we, m_ack;
  logic [AW-1:0] m_addr, mem_addr;
  logic [31:0]   m_wdata, m_rdata, mem_wdata, mem_rdata;
  logic [3:0]    m_be, mem_be;
  logic          mem_req, mem_we, mem_gnt;

  pwb_top #(.DEPTH(CAP), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .flush_set(flush_set),
    .flush_bit(flush_bit), .flush_busy(flush_busy),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
    .m_ack(m_ack), .m_rdata(m_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  // Memory model and architectural shadow.
  logic [31:0] mem_arr [64];
  logic [31:0] arch    [64];
  assign mem_rdata = mem_arr[mem_addr[5:0]];

  function automatic logic [31:0] bytes_in(logic [31:0] old_v, logic [31:0] new_v, logic [3:0] en);
    logic [31:0] r;
    r = old_v;
    if (en[0]) r[7:0]   = new_v[7:0];
    if (en[1]) r[15:8]  = new_v[15:8];
    if (en[2]) r[23:16] = new_v[23:16];
    if (en[3]) r[31:24] = new_v[31:24];
    return r;
  endfunction

  always @(posedge clk)
    if (mem_req && mem_we && mem_gnt)
      mem_arr[mem_addr[5:0]] <= bytes_in(mem_arr[mem_addr[5:0]], mem_wdata, mem_be);

  typedef struct {
    int          a;
    logic [31:0] d;
    logic [3:0]  b;
  } post_t;
  post_t q[$];

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    bit pend;
    bit fb_m;
    int fillcnt;
    for (int i = 0; i < 64; i++) begin
      mem_arr[i] = 32'hA5000000 ^ (i * 32'h01010101);
      arch[i]    = 32'hA5000000 ^ (i * 32'h01010101);
    end
    wb_en = 0; flush_set = 0; m_req = 0; m_we = 0; m_addr = '0;
    m_wdata = '0; m_be = '0; mem_gnt = 0;
    pend = 0; fb_m = 0; fillcnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "flush_bit after reset", 32'(flush_bit), 32'd0);
    chk("R1", "flush_busy after reset", 32'(flush_busy), 32'd0);
    chk("R1", "mem_req idle after reset", 32'(mem_req), 32'd0);

    for (int c = 0; c < NCYC; c++) begin
      bit quiet, fill, gnt_rand, gnt_on, gnt_off;
      bit busy_m, empty_m, rd_go, wr_pass, wr_buf, buf_ok, drain, exp_ack, exp_mreq;
      int hit_idx, qn;
      string tag;
      @(negedge clk);
      // control schedule
      if (c < 200) wb_en = 0;
      else if (c < 830) wb_en = 1;
      else if (c < 900) wb_en = 0;
      else if (c < 1200) wb_en = 1;
      else wb_en = ((c / 30) % 2 == 0);
      flush_set = (c == 732) || (c >= 900 && c < 1200 && c % 97 == 0);
      quiet    = (c >= 590 && c < 600) || (c >= 690 && c < 700) || (c >= 790 && c < 800);
      fill     = (c >= 600 && c < 640) || (c >= 700 && c < 730) || (c >= 800 && c < 830);
      gnt_off  = fill;
      gnt_on   = quiet || (c >= 640 && c < 660);
      gnt_rand = !gnt_off && !gnt_on;
      mem_gnt  = gnt_on ? 1'b1 : (gnt_rand ? 1'($urandom_range(0, 1)) : 1'b0);
      // master stimulus: new op only after acknowledge
      if (!pend && !quiet) begin
        if (fill) begin
          m_req = 1; m_we = 1; m_addr = AW'(8 + (fillcnt % 8)); fillcnt++;
          m_wdata = $urandom; m_be = 4'($urandom_range(1, 15)); pend = 1;
        end else begin
          int r;
          r = $urandom_range(0, 9);
          if (r < 2) m_req = 0;
          else begin
            m_req = 1; m_we = (r >= 5); m_addr = AW'($urandom_range(0, 11));
            m_wdata = $urandom; m_be = 4'($urandom_range(1, 15)); pend = 1;
          end
        end
      end else if (!pend) m_req = 0;
      #1;
      // reference model
      qn = q.size();
      empty_m = (qn == 0);
      busy_m  = (fb_m || !wb_en) && !empty_m;
      hit_idx = -1;
      for (int i = 0; i < qn; i++) if (q[i].a == int'(m_addr)) hit_idx = i;
      rd_go   = m_req && !m_we && !busy_m;
      wr_pass = m_req && m_we && !wb_en && empty_m;
      wr_buf  = m_req && m_we && wb_en && !busy_m;
      buf_ok  = wr_buf && ((hit_idx >= 0) ? (hit_idx != 0) : (qn < CAP));
      drain   = !empty_m && !rd_go;
      exp_ack = ((rd_go || wr_pass) && mem_gnt) || buf_ok;
      exp_mreq = rd_go || wr_pass || drain;
      if (busy_m) tag = "R8";
      else if (rd_go) tag = "R6";
      else if (wr_pass) tag = "R1";
      else if (hit_idx >= 0) tag = "R3";
      else if (qn == CAP) tag = "R4";
      else tag = "R2";

      chk(tag, "m_ack", 32'(m_ack), 32'(exp_ack));
      chk("R8", "flush_busy", 32'(flush_busy), 32'(busy_m));
      chk("R9", "flush_bit", 32'(flush_bit), 32'(fb_m));
      chk(rd_go ? "R7" : "R5", "mem_req", 32'(mem_req), 32'(exp_mreq));
      if (exp_mreq && mem_req) begin
        if (rd_go) begin
          // R7: read goes first even with writes posted
          chk("R7", "mem_we on read", 32'(mem_we), 32'd0);
          chk("R7", "read mem_addr", 32'(mem_addr), 32'(m_addr));
        end else if (wr_pass) begin
          chk("R1", "pass mem_we", 32'(mem_we), 32'd1);
          chk("R1", "pass mem_addr", 32'(mem_addr), 32'(m_addr));
          chk("R1", "pass mem_wdata", mem_wdata, m_wdata);
          chk("R1", "pass mem_be", 32'(mem_be), 32'(m_be));
        end else begin
          // R5 drain order; R3 folded contents show up here
          chk("R5", "drain mem_we", 32'(mem_we), 32'd1);
          chk("R5", "drain mem_addr", 32'(mem_addr), 32'(q[0].a));
          chk("R5", "drain mem_wdata lanes", bytes_in(32'd0, mem_wdata, q[0].b),
              bytes_in(32'd0, q[0].d, q[0].b));
          chk("R5", "drain mem_be", 32'(mem_be), 32'(q[0].b));
        end
      end
      if (rd_go && mem_gnt && m_ack)
        chk("R6", "merged read data", m_rdata, arch[m_addr[5:0]]);

      // model state update
      if (drain && mem_gnt) begin
        void'(q.pop_front());
        if (hit_idx >= 0) hit_idx--;
      end
      if (buf_ok) begin
        if (hit_idx >= 0) begin
          q[hit_idx].d = bytes_in(q[hit_idx].d, m_wdata, m_be);
          q[hit_idx].b = q[hit_idx].b | m_be;
        end else begin
          post_t e;
          e.a = int'(m_addr); e.d = m_wdata; e.b = m_be;
          q.push_back(e);
        end
      end
      if (m_ack && m_we) arch[m_addr[5:0]] = bytes_in(arch[m_addr[5:0]], m_wdata, m_be);
      if (flush_set) fb_m = 1;
      else if (empty_m) fb_m = 0;
      chk("R4", "entry count bound", 32'(q.size() <= CAP), 32'd1);
      if (m_ack) pend = 0;
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule